// File: doc/BRIEF.md
# Hamming Sector ECC Checker-Corrector

This block checks one 512-byte data sector against its single-error-correcting Hamming code. The software or sequencer feeding it supplies two 24-bit codes: the one kept in the flash spare area and the one generated while the sector streamed in. On a start strobe the block spreads each code into a 32-bit word and XORs the two words. It then sorts the result into one of five verdicts: clean, one correctable data bit, a corrupted code field, an erased page, or an uncorrectable error.

The sector sits in a local byte-wide buffer. The host fills and drains this buffer through a simple synchronous port. For a correctable error, the engine takes over the buffer port for a read cycle and then a write cycle, and flips the faulty bit in place. A one-cycle done pulse marks the end of each check. The verdict and the location of the corrected bit stay on the outputs until the next check finishes.

Top module: `hamming_sector_fixer`

## Requirements
- R1: Each 24-bit code is taken as byte0 = bits 7:0, byte1 = bits 15:8, byte2 = bits 23:16. It is spread into a 32-bit word: byte0 goes to 7:0, byte1 to 23:16, the upper nibble of byte2 to 27:24 and the lower nibble of byte2 to 11:8. All other bits are zero. The syndrome is the XOR of the two spread words. A zero syndrome gives status 0 (clean) and leaves the buffer untouched.
- R2: A syndrome with exactly 12 ones gives status 1 (corrected). In that case fix_bit = syndrome[18:16] and fix_byte = syndrome[27:19]. Buffer byte fix_byte has bit fix_bit inverted and no other bit changed.
- R3: A syndrome with exactly one 1 gives status 2 (code field corrupt), and the buffer is left unchanged.
- R4: A stored word equal to 0x0FFF0FFF (stored code 0xFFFFFF) together with a computed word of zero gives status 3 (erased).
- R5: Any other nonzero syndrome gives status 4 (uncorrectable), and the buffer is left unchanged.
- R6: done is high for exactly one cycle per accepted start. A start sampled on clock edge E0 raises done after edge E1 when the status is not 1, and after edge E3 when the status is 1. busy is high from E0 until done rises.
- R7: status, fix_byte and fix_bit change only at the edge that raises done, and hold between checks. For any status other than 1, fix_byte and fix_bit are zero.
- R8: While busy is low, the host buffer port works as follows. With buf_en high, buf_we high writes buf_wdata at buf_addr. With buf_en high, buf_rdata shows the byte at buf_addr after the next clock edge.
- R9: While busy is high, host buffer accesses are ignored and start is ignored. No extra done pulse follows an ignored start.
- R10: After synchronous reset, busy and done are low, status is 0, and fix_byte and fix_bit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check with the presented codes |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code computed over the sector |
| buf_en | input | 1 | Host buffer access enable |
| buf_we | input | 1 | Host buffer write enable |
| buf_addr | input | 9 | Host buffer byte address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Buffer read data, one cycle latency |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle end-of-check pulse |
| status | output | 3 | Verdict: 0 clean, 1 corrected, 2 code corrupt, 3 erased, 4 uncorrectable |
| fix_byte | output | 9 | Byte index of the corrected bit |
| fix_bit | output | 3 | Bit index of the corrected bit |

## Verification
Matching codes, both zero and nonzero, confirm that only the syndrome matters. Twelve-weight syndromes aimed at byte 0 bit 0, byte 5 bit 3 and byte 511 bit 7 check the location slicing at both ends of the buffer and the in-place flip. Single-bit differences, one in the low byte and one in the nibble that lands in bits 27:24, separate the corrupt-code verdict from the others. The all-ones stored code with a zero computed code is paired with a near miss and with the reversed pair, which shows that the erased exception needs both conditions. Two-bit differences cover the uncorrectable case, and a full buffer scan afterwards shows that no verdict other than a correction wrote to the buffer.

// File: rtl/ham_fix_pkg.sv
package ham_fix_pkg;
  localparam int SECTOR_BYTES = 512;
  localparam int BYTE_W       = 8;
  localparam int IDX_W        = $clog2(SECTOR_BYTES);
  localparam int BIT_W        = $clog2(BYTE_W);
  localparam int CODE_W       = 24;
  localparam int WORD_W       = 32;
  localparam int WEIGHT_W     = $clog2(WORD_W + 1);
  localparam logic [WORD_W-1:0] BLANK_WORD = 32'h0FFF_0FFF;

  typedef enum logic [2:0] {
    V_CLEAN    = 3'd0,
    V_FIXED    = 3'd1,
    V_CODE_BAD = 3'd2,
    V_ERASED   = 3'd3,
    V_MULTI    = 3'd4
  } verdict_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_EVAL,
    PH_READ,
    PH_WRITE
  } phase_e;
endpackage

// File: rtl/ham_code_repack.sv
module ham_code_repack
  import ham_fix_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o        = '0;
    word_o[7:0]   = code_i[7:0];
    word_o[23:16] = code_i[15:8];
    word_o[27:24] = code_i[23:20];
    word_o[11:8]  = code_i[19:16];
  end
endmodule

// File: rtl/ham_syndrome_classify.sv
module ham_syndrome_classify
  import ham_fix_pkg::*;
#(
  parameter int SINGLE_WEIGHT = 12
) (
  input  logic [WORD_W-1:0] stored_w,
  input  logic [WORD_W-1:0] calc_w,
  output verdict_e          verdict,
  output logic [IDX_W-1:0]  loc_byte,
  output logic [BIT_W-1:0]  loc_bit
);
  logic [WORD_W-1:0]   synd;
  logic [WEIGHT_W-1:0] weight;

  assign synd = stored_w ^ calc_w;

  always_comb begin
    weight = '0;
    for (int i = 0; i < WORD_W; i++) begin
      weight = weight + WEIGHT_W'(synd[i]);
    end
  end

  always_comb begin
    if (synd == '0)
      verdict = V_CLEAN;
    else if (weight == WEIGHT_W'(SINGLE_WEIGHT))
      verdict = V_FIXED;
    else if (weight == WEIGHT_W'(1))
      verdict = V_CODE_BAD;
    else if ((stored_w == BLANK_WORD) && (calc_w == '0))
      verdict = V_ERASED;
    else
      verdict = V_MULTI;
  end

  assign loc_bit  = synd[16 +: BIT_W];
  assign loc_byte = synd[16 + BIT_W +: IDX_W];
endmodule

// File: rtl/ham_sector_buf.sv
module ham_sector_buf #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer
  import ham_fix_pkg::*;
#(
  parameter int SINGLE_WEIGHT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [23:0]       stored_code,
  input  logic [23:0]       calc_code,
  input  logic              buf_en,
  input  logic              buf_we,
  input  logic [8:0]        buf_addr,
  input  logic [7:0]        buf_wdata,
  output logic [7:0]        buf_rdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status,
  output logic [8:0]        fix_byte,
  output logic [2:0]        fix_bit
);
  phase_e                phase_q;
  logic [1:0][CODE_W-1:0] code_q;
  logic [1:0][WORD_W-1:0] word_w;
  verdict_e              verdict;
  logic [IDX_W-1:0]      cls_byte, pend_byte_q, fix_byte_q;
  logic [BIT_W-1:0]      cls_bit, pend_bit_q, fix_bit_q;
  logic [2:0]            status_q;
  logic                  done_q;

  logic                  ram_en, ram_we;
  logic [IDX_W-1:0]      ram_addr;
  logic [BYTE_W-1:0]     ram_wdata, ram_rdata, flip_mask;

  for (genvar g = 0; g < 2; g++) begin : g_repack
    ham_code_repack u_rp (
      .code_i (code_q[g]),
      .word_o (word_w[g])
    );
  end

  ham_syndrome_classify #(
    .SINGLE_WEIGHT (SINGLE_WEIGHT)
  ) u_cls (
    .stored_w (word_w[0]),
    .calc_w   (word_w[1]),
    .verdict  (verdict),
    .loc_byte (cls_byte),
    .loc_bit  (cls_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      code_q      <= '0;
      pend_byte_q <= '0;
      pend_bit_q  <= '0;
      status_q    <= 3'(V_CLEAN);
      fix_byte_q  <= '0;
      fix_bit_q   <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            code_q[0] <= stored_code;
            code_q[1] <= calc_code;
            phase_q   <= PH_EVAL;
          end
        end
        PH_EVAL: begin
          if (verdict == V_FIXED) begin
            pend_byte_q <= cls_byte;
            pend_bit_q  <= cls_bit;
            phase_q     <= PH_READ;
          end else begin
            status_q   <= 3'(verdict);
            fix_byte_q <= '0;
            fix_bit_q  <= '0;
            done_q     <= 1'b1;
            phase_q    <= PH_IDLE;
          end
        end
        PH_READ: phase_q <= PH_WRITE;
        PH_WRITE: begin
          status_q   <= 3'(V_FIXED);
          fix_byte_q <= pend_byte_q;
          fix_bit_q  <= pend_bit_q;
          done_q     <= 1'b1;
          phase_q    <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    flip_mask = '0;
    flip_mask[pend_bit_q] = 1'b1;
  end

  always_comb begin
    if (phase_q != PH_IDLE) begin
      ram_en    = (phase_q == PH_READ) || (phase_q == PH_WRITE);
      ram_we    = (phase_q == PH_WRITE);
      ram_addr  = pend_byte_q;
      ram_wdata = ram_rdata ^ flip_mask;
    end else begin
      ram_en    = buf_en;
      ram_we    = buf_we;
      ram_addr  = buf_addr;
      ram_wdata = buf_wdata;
    end
  end

  ham_sector_buf #(
    .DEPTH  (SECTOR_BYTES),
    .DATA_W (BYTE_W)
  ) u_buf (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign buf_rdata = ram_rdata;
  assign busy      = (phase_q != PH_IDLE);
  assign done      = done_q;
  assign status    = status_q;
  assign fix_byte  = fix_byte_q;
  assign fix_bit   = fix_bit_q;
endmodule

// File: rtl/ham_fix_checker.sv
module ham_fix_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic [8:0] fix_byte,
  input logic [2:0] fix_bit
);
  logic rst_seen_q;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q) begin
      AST_RESET_STATE: assert (!busy && !done && status == 3'd0 && fix_byte == 9'd0 && fix_bit == 3'd0) // R10
        else $error("reset state wrong");
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done) // R6
    else $error("done longer than one cycle");

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy) // R6
    else $error("done while busy");

  AST_FIX_LATENCY: assert property (@(posedge clk) disable iff (rst) (done && status == 3'd1) |-> $past(busy, 2)) // R2
    else $error("correction too fast");

  AST_FAST_VERDICT: assert property (@(posedge clk) disable iff (rst) (done && status != 3'd1) |-> !$past(busy, 2)) // R6
    else $error("non-correcting verdict too slow");

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst) !$rose(done) |-> ($stable(status) && $stable(fix_byte) && $stable(fix_bit))) // R7
    else $error("status moved without done");

  AST_LOC_ZERO: assert property (@(posedge clk) disable iff (rst) (done && status != 3'd1) |-> (fix_byte == 9'd0 && fix_bit == 3'd0)) // R7
    else $error("location nonzero without correction");

  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (rst) done |-> (status <= 3'd4)) // R5
    else $error("status code out of range");
endmodule

bind hamming_sector_fixer ham_fix_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .status   (status),
  .fix_byte (fix_byte),
  .fix_bit  (fix_bit)
);

// File: tb/tb_hamming_sector_fixer.sv
module tb_hamming_sector_fixer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [23:0] stored_code = '0, calc_code = '0;
  logic       buf_en = 1'b0, buf_we = 1'b0;
  logic [8:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic       busy, done;
  logic [2:0] status;
  logic [8:0] fix_byte;
  logic [2:0] fix_bit;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hamming_sector_fixer dut (
    .clk(clk), .rst(rst), .start(start),
    .stored_code(stored_code), .calc_code(calc_code),
    .buf_en(buf_en), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .busy(busy), .done(done), .status(status),
    .fix_byte(fix_byte), .fix_bit(fix_bit)
  );

  // {stored[62:39], calc[38:15], status[14:12], byte[11:3], bit[2:0]}
  localparam int NV = 11;
  localparam logic [62:0] VEC [NV] = '{
    {24'h123456, 24'h123456, 3'd0, 9'd0,   3'd0},  // R1 equal codes
    {24'h000000, 24'h0F2BD4, 3'd1, 9'd5,   3'd3},  // R2 byte 5 bit 3
    {24'hA5A5A5, 24'h555AA5, 3'd1, 9'd511, 3'd7},  // R2 last byte
    {24'h0F00FF, 24'h000000, 3'd1, 9'd0,   3'd0},  // R2 first byte
    {24'h000010, 24'h000000, 3'd2, 9'd0,   3'd0},  // R3 low byte
    {24'h800000, 24'h000000, 3'd2, 9'd0,   3'd0},  // R3 upper nibble
    {24'hFFFFFF, 24'h000000, 3'd3, 9'd0,   3'd0},  // R4 erased
    {24'hFFFFFF, 24'h000001, 3'd4, 9'd0,   3'd0},  // R5 near erased
    {24'h000003, 24'h000000, 3'd4, 9'd0,   3'd0},  // R5 two bits
    {24'h000000, 24'hFFFFFF, 3'd4, 9'd0,   3'd0},  // R5 reversed blank
    {24'h3C3C3C, 24'h3C3C3C, 3'd0, 9'd0,   3'd0}   // R1 nonzero equal
  };

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h3C;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    buf_en = 1'b1; buf_we = 1'b1; buf_addr = 9'(a); buf_wdata = d;
    @(negedge clk);
    buf_en = 1'b0; buf_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [7:0] d);
    buf_en = 1'b1; buf_we = 1'b0; buf_addr = 9'(a);
    @(negedge clk);
    buf_en = 1'b0;
    d = buf_rdata;
  endtask

  task automatic run_check(input logic [23:0] s, input logic [23:0] c, output int lat);
    stored_code = s; calc_code = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int lat, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "status", status, 0);
    chk("R10", "location", {fix_byte, fix_bit}, 0);

    for (int a = 0; a < 512; a++) host_write(a, pat(a));
    host_read(37, rd);
    chk("R8", "read byte 37", rd, pat(37));
    host_read(511, rd);
    chk("R8", "read byte 511", rd, pat(511));

    for (int v = 0; v < NV; v++) begin
      run_check(VEC[v][62:39], VEC[v][38:15], lat);
      chk("R6", $sformatf("vec%0d latency", v), lat, (VEC[v][14:12] == 3'd1) ? 4 : 2);
      chk("R1-5", $sformatf("vec%0d status", v), status, VEC[v][14:12]);
      chk("R7", $sformatf("vec%0d location", v), {fix_byte, fix_bit}, VEC[v][11:0]);
      if (VEC[v][14:12] == 3'd1) begin
        host_read(VEC[v][11:3], rd);
        chk("R2", $sformatf("vec%0d flipped byte", v), rd,
            pat(VEC[v][11:3]) ^ (8'd1 << VEC[v][2:0]));
        host_write(VEC[v][11:3], pat(VEC[v][11:3]));
      end
    end

    repeat (5) @(negedge clk);
    chk("R7", "status holds", status, 0);
    chk("R7", "no stray done", done, 0);

    bad = 0;
    for (int a = 0; a < 512; a++) begin
      host_read(a, rd);
      if (rd != pat(a)) bad++;
    end
    chk("R3 R5", "buffer untouched by other verdicts", bad, 0);

    // R9: host write and second start during a correction are ignored
    stored_code = 24'h000000; calc_code = 24'h0F2BD4; start = 1'b1;
    @(negedge clk);
    chk("R9", "busy after start", busy, 1);
    stored_code = 24'h111111; calc_code = 24'h111111;
    buf_en = 1'b1; buf_we = 1'b1; buf_addr = 9'd5; buf_wdata = 8'h00;
    @(negedge clk);
    start = 1'b0; buf_en = 1'b0; buf_we = 1'b0;
    lat = 2;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk("R9", "latency unchanged", lat, 4);
    chk("R9", "status kept", status, 1);
    bad = 0;
    repeat (4) begin
      @(negedge clk);
      if (done) bad++;
    end
    chk("R9", "no extra done", bad, 0);
    host_read(5, rd);
    chk("R9", "host write dropped", rd, pat(5) ^ 8'h08);
    host_write(5, pat(5));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule